// File: doc/BRIEF.md
# Multiplexed Frequency-to-BCD Input Counter

This block measures the frequency of one of sixteen slow digital square-wave lines. A window of a programmed number of system clocks is opened with a start strobe. During the window the block counts the rising edges of the chosen line. The result is held in four decimal decades and is presented as a packed BCD word. The reading stays valid from the done pulse until the next start.

The sixteen lines are split into two banks of eight. The top bit of the channel select enables one bank and inhibits the other, so the inhibited bank passes nothing. The three low bits pick the line within the enabled bank. The select is captured at start, so changing it during a window has no effect on that window.

The counter is a decimal cascade. Each decade steps when the decade below it wraps from 9 to 0. When the count would go past 9999 it stays at 9999 and an overflow flag is raised. The flag holds until the next start.

Each line is expected to carry no more than a few hundred hertz, far below the system clock. All control and status pins are plain levels and pulses. There is no streamed data, so there is no valid/ready handshake and no back-pressure.

Top module: `fbc_top`

## Requirements
- R1: Within the enabled bank, `chan_sel[2:0]` picks line `8*chan_sel[3] + chan_sel[2:0]` of `pulse_in`. Edges on any other line of that bank are not counted.
- R2: `chan_sel[3]` enables bank 0 (lines 0..7) when 0 and bank 1 (lines 8..15) when 1. Edges on the inhibited bank are never counted.
- R3: After a window, `count_bcd` holds the number of rising edges of the selected line seen during the window. Digit k occupies bits `[4k+3:4k]`, and digit 0 (bits 3:0) is the units digit.
- R4: Every decade of `count_bcd` is always in the range 0 to 9.
- R5: A decade above the units advances only in the cycle where the decade below it goes from 9 to 0. For example 9 becomes 10, 99 becomes 100 and 999 becomes 1000.
- R6: While `rst` is high, `count_bcd` is 0, `done` is 0 and `overflow` is 0. A window in progress is abandoned and gives no `done`.
- R7: `done` is high for exactly one cycle, `gate_len` clock edges after the edge that samples `start`. A `gate_len` of 0 behaves as 1. After `done`, `count_bcd` does not change until the next start.
- R8: Once 9999 edges have been counted, further edges leave `count_bcd` at 9999 and set `overflow`.
- R9: A sampled `start` clears `count_bcd` and `overflow`, captures `chan_sel` and `gate_len`, and restarts any window in progress. Changes to `chan_sel` during a window are ignored.
- R10: The selected line is synchronized by two flops. Each rising edge is counted once, provided its high and low phases each last at least two clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| chan_sel | input | 4 | Channel select; bit 3 picks the bank, bits 2:0 the line in the bank |
| pulse_in | input | 16 | Asynchronous square-wave lines |
| start | input | 1 | Opens a new measurement window |
| gate_len | input | 24 | Window length in clock cycles |
| count_bcd | output | 16 | Four packed BCD digits, units digit in bits 3:0 |
| done | output | 1 | One-cycle pulse when the window closes |
| overflow | output | 1 | Count saturated at 9999 in this window |

## Verification
The carry corner cases are run at 9, 10, 99, 100, 999 and 1000 edges. A cascade that carried on the wrong transition, or that let a digit reach 10, would show a hex digit or a missing or doubled tens, hundreds or thousands step.

Bank isolation is tested by driving the line that has the same low select bits in the other bank. A mux that ignored the inhibit would count those edges.

A select change in mid-window and a run of 10005 edges are also applied. These catch a design that follows the live select, or one that wraps past 9999 to 0000. The exact `done` cycle is checked for lengths of 5 and 0, which exposes off-by-one window counters.

// File: rtl/fbc_pkg.sv
package fbc_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } fbc_state_e;

  localparam logic [3:0] BCD_MAX = 4'd9;
endpackage

// File: rtl/fbc_bank_mux.sv
module fbc_bank_mux #(
  parameter int NCH   = 16,
  parameter int BANKS = 2
) (
  input  logic [$clog2(NCH)-1:0] sel,
  input  logic [NCH-1:0]         lines,
  output logic                   out
);
  localparam int PER = NCH / BANKS;
  localparam int SW  = $clog2(NCH);
  localparam int LW  = $clog2(PER);
  localparam int BW  = SW - LW;

  logic [BANKS-1:0] bank_en;
  logic [BANKS-1:0] bank_hit;

  // Each bank is enabled by the high select bits; an inhibited bank drives 0.
  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [PER-1:0] bank_lines;
    assign bank_lines  = lines[b*PER +: PER];
    assign bank_en[b]  = (sel[SW-1:LW] == BW'(b));
    assign bank_hit[b] = bank_en[b] & bank_lines[sel[LW-1:0]];
  end

  assign out = |bank_hit;
endmodule

// File: rtl/fbc_sync.sv
module fbc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous value.
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], din};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];

  // R10: one edge gives a single-cycle count strobe
  a_r10_single_strobe: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/fbc_bcd_cascade.sv
module fbc_bcd_cascade #(
  parameter int DIGITS = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clear,
  input  logic                inc,
  output logic [4*DIGITS-1:0] digits,
  output logic                sat_hit
);
  import fbc_pkg::*;

  logic [4*DIGITS-1:0] q;
  logic [DIGITS:0]     carry;

  assign carry[0] = inc;
  for (genvar d = 0; d < DIGITS; d++) begin : g_carry
    assign carry[d+1] = carry[d] & (q[4*d +: 4] == BCD_MAX);
  end

  // An increment with every decade at 9 would wrap: hold instead.
  assign sat_hit = carry[DIGITS];

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      q <= '0;
    end else if (!sat_hit) begin
      for (int d = 0; d < DIGITS; d++) begin
        if (carry[d]) q[4*d +: 4] <= (q[4*d +: 4] == BCD_MAX) ? 4'd0 : q[4*d +: 4] + 4'd1;
      end
    end
  end

  assign digits = q;

  for (genvar d = 0; d < DIGITS; d++) begin : g_chk
    // R4: decimal range of every decade
    a_r4_digit_range: assert property (@(posedge clk) disable iff (rst)
      q[4*d +: 4] <= BCD_MAX);
    if (d > 0) begin : g_up
      // R5: an upper decade moves only on the 9-to-0 fall of the one below
      a_r5_carry_on_fall: assert property (@(posedge clk) disable iff (rst)
        (!$past(clear) && (q[4*d +: 4] != $past(q[4*d +: 4])))
          |-> ($past(q[4*(d-1) +: 4]) == BCD_MAX && q[4*(d-1) +: 4] == 4'd0));
    end
  end
endmodule

// File: rtl/fbc_top.sv
module fbc_top #(
  parameter int NCH         = 16,
  parameter int BANKS       = 2,
  parameter int DIGITS      = 4,
  parameter int GATE_W      = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [3:0]            chan_sel,
  input  logic [NCH-1:0]        pulse_in,
  input  logic                  start,
  input  logic [GATE_W-1:0]     gate_len,
  output logic [4*DIGITS-1:0]   count_bcd,
  output logic                  done,
  output logic                  overflow
);
  import fbc_pkg::*;

  localparam int SEL_W = $clog2(NCH);
  localparam logic [4*DIGITS-1:0] FULL_SCALE = {DIGITS{BCD_MAX}};

  fbc_state_e        state;
  logic [GATE_W-1:0] remain;
  logic [SEL_W-1:0]  sel_q;
  logic              done_q;
  logic              ovf_q;
  logic              sel_pulse;
  logic              rise;
  logic              inc;
  logic              sat_hit;

  fbc_bank_mux #(.NCH(NCH), .BANKS(BANKS)) u_mux (
    .sel   (sel_q),
    .lines (pulse_in),
    .out   (sel_pulse)
  );

  fbc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (sel_pulse),
    .rise (rise)
  );

  assign inc = rise & (state == ST_RUN) & ~start;

  fbc_bcd_cascade #(.DIGITS(DIGITS)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .clear   (start),
    .inc     (inc),
    .digits  (count_bcd),
    .sat_hit (sat_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      remain <= '0;
      sel_q  <= '0;
      done_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        state  <= ST_RUN;
        remain <= gate_len;
        sel_q  <= chan_sel[SEL_W-1:0];
        ovf_q  <= 1'b0;
      end else if (state == ST_RUN) begin
        if (sat_hit) ovf_q <= 1'b1;
        if (remain <= GATE_W'(1)) begin
          state  <= ST_IDLE;
          done_q <= 1'b1;
        end else begin
          remain <= remain - GATE_W'(1);
        end
      end
    end
  end

  assign done     = done_q;
  assign overflow = ovf_q;

  // R7: done lasts a single cycle
  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R7: result frozen outside a window
  a_r7_count_frozen: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !start) |=> $stable(count_bcd));
  // R8: overflow only with a saturated count
  a_r8_sat_value: assert property (@(posedge clk) disable iff (rst)
    overflow |-> (count_bcd == FULL_SCALE));
  // R1/R2: the muxed level comes only from the captured line
  a_r2_bank_isolation: assert property (@(posedge clk) disable iff (rst)
    sel_pulse |-> pulse_in[sel_q]);
  // R9: captured select holds for the whole window
  a_r9_sel_hold: assert property (@(posedge clk) disable iff (rst)
    (!start && state == ST_RUN) |=> (sel_q == $past(sel_q)));
endmodule

// File: tb/tb_fbc_top.sv
module tb_fbc_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  chan_sel = '0;
  logic [15:0] pulse_in = '0;
  logic        start = 1'b0;
  logic [23:0] gate_len = '0;
  logic [15:0] count_bcd;
  logic        done;
  logic        overflow;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  fbc_top dut (
    .clk(clk), .rst(rst), .chan_sel(chan_sel), .pulse_in(pulse_in),
    .start(start), .gate_len(gate_len), .count_bcd(count_bcd),
    .done(done), .overflow(overflow)
  );

  // {channel, edges, half period, unused}
  localparam int VEC [0:8][0:3] = '{
    '{0,    0, 2, 0},
    '{3,    1, 2, 0},
    '{7,    9, 3, 0},
    '{8,   10, 2, 0},
    '{15,  99, 2, 0},
    '{10, 100, 5, 0},
    '{5,  999, 2, 0},
    '{12, 1000, 2, 0},
    '{9,  1234, 2, 0}
  };

  function automatic logic [15:0] to_bcd(int v);
    logic [15:0] r = '0;
    int x = (v > 9999) ? 9999 : v;
    for (int i = 0; i < 4; i++) begin
      r[4*i +: 4] = 4'(x % 10);
      x = x / 10;
    end
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic kick(int ch, int g);
    chan_sel = 4'(ch);
    gate_len = 24'(g);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic pulse(int ch, int n, int half);
    for (int k = 0; k < n; k++) begin
      pulse_in[ch] = 1'b1;
      repeat (half) @(negedge clk);
      pulse_in[ch] = 1'b0;
      repeat (half) @(negedge clk);
    end
  endtask

  task automatic wait_done(int lim, output int cyc);
    cyc = -1;
    for (int i = 1; i <= lim; i++) begin
      @(negedge clk);
      if (done) begin
        cyc = i;
        break;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    // R6: reset state
    chk("R6 reset count", 32'(count_bcd), 32'h0);
    chk("R6 reset done", 32'(done), 32'h0);
    chk("R6 reset ovf", 32'(overflow), 32'h0);
    rst = 1'b0;
    @(negedge clk);

    // R3 R5 R1 R10: table of windows, carries at each decade boundary
    for (int v = 0; v < 9; v++) begin
      int ch = VEC[v][0];
      int n  = VEC[v][1];
      int h  = VEC[v][2];
      kick(ch, n * 2 * h + 40);
      pulse(ch, n, h);
      wait_done(100, cyc);
      chk("R3 done seen", 32'(cyc > 0), 32'h1);
      chk("R3 R5 count", 32'(count_bcd), 32'(to_bcd(n)));
      chk("R8 no ovf", 32'(overflow), 32'h0);
    end

    // R7: exact done cycle for gate 5, single-cycle pulse
    kick(1, 5);
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      chk("R7 done timing", 32'(done), 32'(i == 5));
    end
    // R7: gate 0 behaves as 1
    kick(1, 0);
    @(negedge clk);
    chk("R7 gate zero", 32'(done), 32'h1);
    @(negedge clk);
    chk("R7 done drop", 32'(done), 32'h0);

    // R7: count frozen after done
    kick(6, 60);
    pulse(6, 4, 2);
    wait_done(100, cyc);
    pulse(6, 3, 2);
    repeat (5) @(negedge clk);
    chk("R7 frozen", 32'(count_bcd), 32'h4);

    // R2: other bank with same low bits inhibited
    kick(10, 60);
    pulse(2, 5, 2);
    wait_done(100, cyc);
    chk("R2 bank1 ignores ch2", 32'(count_bcd), 32'h0);
    kick(2, 60);
    pulse(10, 5, 2);
    wait_done(100, cyc);
    chk("R2 bank0 ignores ch10", 32'(count_bcd), 32'h0);
    // R1: sibling line in same bank ignored
    kick(3, 60);
    pulse(4, 5, 2);
    pulse(3, 2, 2);
    wait_done(100, cyc);
    chk("R1 sibling ignored", 32'(count_bcd), 32'h2);

    // R9: select change mid-window ignored
    kick(4, 80);
    chan_sel = 4'd5;
    pulse(5, 3, 2);
    pulse(4, 2, 2);
    wait_done(100, cyc);
    chk("R9 select held", 32'(count_bcd), 32'h2);

    // R8: saturation beyond 9999
    kick(11, 10005 * 4 + 40);
    pulse(11, 10005, 2);
    wait_done(100, cyc);
    chk("R8 saturate", 32'(count_bcd), 32'h9999);
    chk("R8 ovf set", 32'(overflow), 32'h1);
    // R9: start clears count and overflow
    kick(11, 30);
    @(negedge clk);
    chk("R9 ovf cleared", 32'(overflow), 32'h0);
    chk("R9 count cleared", 32'(count_bcd), 32'h0);
    wait_done(100, cyc);

    // R6: reset mid-window abandons it
    kick(0, 1000);
    pulse(0, 7, 2);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R6 mid reset count", 32'(count_bcd), 32'h0);
    rst = 1'b0;
    wait_done(1200, cyc);
    chk("R6 no done after reset", 32'(cyc), 32'hFFFF_FFFF);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule